// File: doc/BRIEF.md
# Pulse Peak Capture Sequencer

This block is the digital controller for one detector pulse in a pulse-height acquisition chain. It watches two comparator outputs that arrive asynchronously: one says the shaped pulse has crossed the noise threshold, and the other says the pulse has reached its maximum. From these it drives the control line of an external track-and-hold. When the peak arrives it switches that line to hold and issues a one-clock request to start a conversion.

After the request, the block waits for a conversion-done input. It then clears its capture state and reports one accepted event, which a downstream histogram counts. If conversion-done does not come within a programmable number of clocks, the block clears itself anyway and sets a sticky timeout flag. This keeps the whole peak-to-re-arm sequence shorter than the narrowest expected pulse.

Each comparator input and the done input pass through a two-flop synchroniser and then a rising-edge detector. Two edge-set flags hold the capture state: "armed" and "peak seen". Reset is asynchronous and active-low, and it is released in step with the clock.

Top module: `pulse_capture_seq`

## Requirements
- R1: After reset, track_o, conv_start_o, event_ok_o and timeout_sticky_o are all 0.
- R2: A rising edge on thr_cmp_i sets the armed flag, and track_o is 1 three clocks after the edge enters the block. A peak edge while the block is not armed changes nothing: track_o stays 0 and conv_start_o does not pulse.
- R3: A rising edge on pk_cmp_i while armed sets the peak-seen flag. track_o (1 = track, 0 = hold) drops to 0 three clocks after that edge.
- R4: conv_start_o is high for exactly one clock, in the same cycle that track_o falls. It pulses once per capture. Further peak edges are ignored until the flags are cleared.
- R5: A rising edge on conv_done_i while peak-seen is set clears both flags and pulses event_ok_o for one clock. A done edge while peak-seen is clear is ignored.
- R6: Suppose peak-seen was set at clock edge P and no done edge has cleared it. Then both flags are forced clear at edge P+timeout_lim_i+1, timeout_sticky_o is set at that same edge, and event_ok_o does not pulse. The sticky flag stays set until reset. timeout_lim_i must be held stable while a capture is in progress.
- R7: After a clear, only a new rising edge on thr_cmp_i re-arms the block. A threshold level that stays high across the clear does not re-arm it.
- R8: If a done edge and the timeout expiry fall in the same clock, the done edge wins: event_ok_o pulses and timeout_sticky_o is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_cmp_i | input | 1 | Threshold comparator output (asynchronous) |
| pk_cmp_i | input | 1 | Peak comparator output (asynchronous) |
| conv_done_i | input | 1 | Conversion complete from the converter (asynchronous) |
| timeout_lim_i | input | TO_W | Clocks allowed from peak-seen to done before a forced clear |
| track_o | output | 1 | Track-and-hold control: 1 = track, 0 = hold |
| conv_start_o | output | 1 | One-clock conversion start request |
| event_ok_o | output | 1 | One-clock pulse per completed capture |
| timeout_sticky_o | output | 1 | Set when a capture was cleared by timeout |

## Verification
The hardest case to reach from the ports is the collision between a done edge and the timeout expiry in one clock, because both arrive through separate synchroniser chains. The stimulus counts clocks from the negative edge on which the peak input is driven. It drives conv_done_i exactly timeout_lim_i+1 clocks later, so that both synchronised events land on the same edge. Ignored stimulus is observed at the ports: extra peak edges, a stray done edge and a held-high threshold are each followed by a read of track_o and the event outputs before the next action.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  localparam int PCS_NUM_CMP = 3;

  typedef struct packed {
    logic done;
    logic pk;
    logic thr;
  } pcs_cmp_t;

  typedef enum logic [1:0] {
    CLR_NONE    = 2'd0,
    CLR_DONE    = 2'd1,
    CLR_TIMEOUT = 2'd2
  } pcs_clr_e;

endpackage

// File: rtl/pcs_rst_sync.sv
module pcs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] rst_pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

endmodule

// File: rtl/pcs_sync.sv
module pcs_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        stg_q[i] <= '0;
      end
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) begin
        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pcs_edge.sv
module pcs_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= lvl_i;
    end
  end

  assign rise_o = lvl_i & ~prev_q;

endmodule

// File: rtl/pcs_capture_flags.sv
module pcs_capture_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_rise_i,
  input  logic pk_rise_i,
  input  logic clr_i,
  output logic armed_o,
  output logic peak_o
);

  logic armed_q, armed_d;
  logic peak_q,  peak_d;

  always_comb begin
    armed_d = armed_q;
    peak_d  = peak_q;
    if (clr_i) begin
      armed_d = 1'b0;
      peak_d  = 1'b0;
    end else begin
      if (thr_rise_i) begin
        armed_d = 1'b1;
      end
      if (pk_rise_i && armed_q) begin
        peak_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      peak_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      peak_q  <= peak_d;
    end
  end

  assign armed_o = armed_q;
  assign peak_o  = peak_q;

  // R2
  peak_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(peak_q) |-> $past(armed_q));

endmodule

// File: rtl/pcs_timeout.sv
module pcs_timeout #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic [TO_W-1:0] lim_i,
  output logic            expire_o
);

  logic [TO_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  assign cnt_en = run_i && (cnt_q != lim_i);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expire_o = run_i && (cnt_q == lim_i);

  // R6
  window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= lim_i));

endmodule

// File: rtl/pulse_capture_seq.sv
module pulse_capture_seq
  import pcs_pkg::*;
#(
  parameter int TO_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            thr_cmp_i,
  input  logic            pk_cmp_i,
  input  logic            conv_done_i,
  input  logic [TO_W-1:0] timeout_lim_i,
  output logic            track_o,
  output logic            conv_start_o,
  output logic            event_ok_o,
  output logic            timeout_sticky_o
);

  logic     rst_sync_n;
  pcs_cmp_t raw_vec, sync_vec, rise_vec;
  logic     armed, peak, expire;
  pcs_clr_e clr_cause;
  logic     clr;

  logic hold_n_q, hold_n_d;
  logic evt_q, evt_d;
  logic sticky_q, sticky_d;

  pcs_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign raw_vec = '{done: conv_done_i, pk: pk_cmp_i, thr: thr_cmp_i};

  pcs_sync #(.W(PCS_NUM_CMP), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (raw_vec),
    .q_o   (sync_vec)
  );

  pcs_edge #(.W(PCS_NUM_CMP)) u_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .lvl_i  (sync_vec),
    .rise_o (rise_vec)
  );

  pcs_capture_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .thr_rise_i (rise_vec.thr),
    .pk_rise_i  (rise_vec.pk),
    .clr_i      (clr),
    .armed_o    (armed),
    .peak_o     (peak)
  );

  pcs_timeout #(.TO_W(TO_W)) u_timeout (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run_i    (peak),
    .lim_i    (timeout_lim_i),
    .expire_o (expire)
  );

  // Clear arbitration: a completed conversion outranks the timeout.
  always_comb begin
    clr_cause = CLR_NONE;
    if (peak && rise_vec.done) begin
      clr_cause = CLR_DONE;
    end else if (expire) begin
      clr_cause = CLR_TIMEOUT;
    end
  end

  assign clr = (clr_cause != CLR_NONE);

  always_comb begin
    hold_n_d = ~peak;
    evt_d    = (clr_cause == CLR_DONE);
    sticky_d = sticky_q | (clr_cause == CLR_TIMEOUT);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hold_n_q <= 1'b1;
      evt_q    <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      hold_n_q <= hold_n_d;
      evt_q    <= evt_d;
      sticky_q <= sticky_d;
    end
  end

  assign track_o          = armed & ~peak;
  assign conv_start_o     = hold_n_q & peak;
  assign event_ok_o       = evt_q;
  assign timeout_sticky_o = sticky_q;

  // R4
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    conv_start_o |=> !conv_start_o);

  // R3
  start_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    conv_start_o |-> !track_o);

  // R5
  event_after_peak_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    event_ok_o |-> ($past(peak) && !peak));

  // R8
  event_not_timeout_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    event_ok_o |-> $stable(timeout_sticky_o));

endmodule

// File: tb/pulse_capture_seq_bench.sv
module pulse_capture_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TO_W       = 16;
  localparam int LIM        = 20;
  localparam int EV_START   = 1;
  localparam int EV_ACCEPT  = 2;

  logic            clk;
  logic            rst_n;
  logic            thr, pk, done;
  logic [TO_W-1:0] lim;
  logic            track, cstart, evok, sticky;

  int n_checks = 0;
  int n_fail   = 0;
  bit mon_en   = 0;
  bit finished = 0;
  int exp_q[$];

  pulse_capture_seq #(.TO_W(TO_W)) u_pulse_capture_seq (
    .clk              (clk),
    .rst_n            (rst_n),
    .thr_cmp_i        (thr),
    .pk_cmp_i         (pk),
    .conv_done_i      (done),
    .timeout_lim_i    (lim),
    .track_o          (track),
    .conv_start_o     (cstart),
    .event_ok_o       (evok),
    .timeout_sticky_o (sticky)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic expect_ev(input int ev);
    exp_q.push_back(ev);
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  // Monitor: pops one expected item per observed pulse (R4, R5, R6)
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && (cstart || evok)) begin
        int got;
        got = cstart ? EV_START : EV_ACCEPT;
        n_checks++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R4/R5 unexpected pulse: got %0d expected none at %0t", got, $time);
        end else begin
          int want;
          want = exp_q.pop_front();
          if (got != want) begin
            n_fail++;
            $display("FAIL R4/R5 event: got %0d expected %0d at %0t", got, want, $time);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; thr = 1'b0; pk = 1'b0; done = 1'b0;
    lim = TO_W'(LIM);
    step(3);
    rst_n = 1'b1;
    step(4);
    // R1 reset state
    chk("R1 track", track, 1'b0);
    chk("R1 start", cstart, 1'b0);
    chk("R1 event", evok, 1'b0);
    chk("R1 sticky", sticky, 1'b0);
    mon_en = 1;

    // Basic capture: R2, R3, R4, R5
    thr = 1'b1; step(3);
    chk("R2 armed track", track, 1'b1);
    expect_ev(EV_START);
    pk = 1'b1; step(3);
    chk("R3 hold on peak", track, 1'b0);
    step(1);
    pk = 1'b0; step(2);
    pk = 1'b1; step(4);   // second peak edge, must be ignored (R4)
    chk("R4 still hold", track, 1'b0);
    expect_ev(EV_ACCEPT);
    done = 1'b1; step(3);
    chk("R5 accept pulse", evok, 1'b1);
    chk("R5 track low", track, 1'b0);
    done = 1'b0; pk = 1'b0; thr = 1'b0; step(3);

    // Noise: peak without threshold (R2)
    pk = 1'b1; step(4);
    chk("R2 noise ignored", track, 1'b0);
    pk = 1'b0; step(3);

    // Stray done while armed but not peaked (R5)
    thr = 1'b1; step(3);
    done = 1'b1; step(3);
    chk("R5 idle done ignored", track, 1'b1);
    done = 1'b0; step(2);
    expect_ev(EV_START);
    pk = 1'b1; step(3);
    expect_ev(EV_ACCEPT);
    done = 1'b1; step(3);
    done = 1'b0; step(4);
    // R7 threshold level still high after the clear
    chk("R7 level no rearm", track, 1'b0);
    thr = 1'b0; pk = 1'b0; step(3);
    thr = 1'b1; step(3);
    chk("R7 new edge rearms", track, 1'b1);
    thr = 1'b0; step(2);

    // R8 done and timeout in the same clock
    expect_ev(EV_START);
    expect_ev(EV_ACCEPT);
    pk = 1'b1;
    step(LIM + 1);
    done = 1'b1;
    step(3);
    chk("R8 done wins event", evok, 1'b1);
    step(1);
    chk("R8 no sticky", sticky, 1'b0);
    done = 1'b0; pk = 1'b0; step(3);

    // R6 timeout
    thr = 1'b1; step(3);
    chk("R6 armed", track, 1'b1);
    expect_ev(EV_START);
    pk = 1'b1;
    step(3 + LIM);
    chk("R6 sticky not yet", sticky, 1'b0);
    step(1);
    chk("R6 sticky set", sticky, 1'b1);
    chk("R6 no event", evok, 1'b0);
    pk = 1'b0; thr = 1'b0; step(3);
    thr = 1'b1; step(3);
    chk("R6 rearm after forced clear", track, 1'b1);
    expect_ev(EV_START);
    pk = 1'b1; step(3);
    expect_ev(EV_ACCEPT);
    done = 1'b1; step(3);
    done = 1'b0; pk = 1'b0; thr = 1'b0; step(6);
    chk("R6 sticky held", sticky, 1'b1);

    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R4/R5 missing events: got %0d left expected 0", exp_q.size());
    end
    finished = 1;
    report();
  end

endmodule